// File: doc/BRIEF.md
# Inverted Page Table Address Translator

This block translates logical addresses into physical addresses through a table that holds one entry for each physical page. Each entry records which logical page currently occupies that physical page, together with a two-bit protection level. For each access the logical page number is compared with every entry at once. The position of the entry that matches is the physical page number, and the page offset passes through unchanged.

Because the table is indexed by physical page, it always covers the whole of physical memory. A physical page can never appear at two logical addresses. An access that matches no entry, or that the protection level forbids in the current privilege state, raises an abort. Software can then repair the mapping and restart the access.

With the default parameters there are 128 pages of 32 KB, which makes 4 MB of physical space. A logical address has 25 bits and a physical address has 22 bits. Entries are written through a separate port, one entry per cycle. Each request gets a registered response one cycle later.

Top module: `ipt_cam_xlat`

## Requirements
- R1: While rst_ni is low, and after reset is released, `vld_o`, `hit_o`, `abort_o` and `multi_o` are 0. Reset leaves every entry parked at logical page 1023 (all ones) with protection level 3.
- R2: For a request, the logical page number is `la_i[24:15]`. On a match, the response arrives on the clock edge after the request with `vld_o`=1, `hit_o`=1 and `pa_o` = {matching entry index, `la_i[14:0]`}.
- R3: A request whose page number matches no entry responds with `hit_o`=0 and `abort_o`=1.
- R4: In user state (`os_i`=0, `sup_i`=0), a hit on level 0 allows both reads and writes. A hit on level 1 allows reads only. Levels 2 and 3 deny all access. A denied access sets `abort_o`=1.
- R5: In OS state (`os_i`=1, `sup_i`=0), reads are allowed at every level. Writes follow the user rule of R4.
- R6: In supervisor state (`sup_i`=1, which overrides `os_i`), any hit is allowed, so `abort_o`=0. A miss still aborts.
- R7: If several entries hold the same logical page, the lowest index wins and `multi_o`=1. With a single match, `multi_o`=0.
- R8: A write on the programming port (`prog_i`=1) updates entry `prog_idx_i` at the clock edge. A request presented in that same cycle is translated against the old contents. Requests from the next cycle on see the new contents.
- R9: Writing an entry with a new logical page removes its old mapping, so the old logical page then misses.
- R10: In a cycle with no request, the next cycle shows `vld_o`=0, `hit_o`=0, `abort_o`=0 and `multi_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request strobe |
| la_i | input | 25 | Logical address |
| we_i | input | 1 | Access is a write |
| os_i | input | 1 | OS privilege state |
| sup_i | input | 1 | Supervisor state, bypasses protection |
| prog_i | input | 1 | Write one table entry |
| prog_idx_i | input | 7 | Physical page (entry) to write |
| prog_lpn_i | input | 10 | Logical page to store |
| prog_prot_i | input | 2 | Protection level to store |
| vld_o | output | 1 | Response valid |
| pa_o | output | 22 | Physical address |
| hit_o | output | 1 | Some entry matched |
| abort_o | output | 1 | Miss or protection violation |
| multi_o | output | 1 | More than one entry matched |

## Verification
Every response is due on the first clock edge after its request. The bench drives a request on a falling edge and samples the outputs on the next falling edge, exactly one register stage later. A table write also lands on one edge. The bench therefore places a request in the same cycle as a write to see the old contents, and places the following request one cycle later to see the new contents. An idle cycle is sampled in the same way to confirm that the response flags drop.

// File: rtl/ipt_cam_pkg.sv
package ipt_cam_pkg;
  localparam int unsigned PROT_W = 2;
  typedef logic [PROT_W-1:0] prot_t;
  // protection levels
  localparam prot_t PROT_RW   = 2'd0;
  localparam prot_t PROT_RO   = 2'd1;
  localparam prot_t PROT_PARK = 2'd3;
endpackage

// File: rtl/ipt_cam_entry.sv
module ipt_cam_entry
  import ipt_cam_pkg::*;
#(
  parameter int unsigned LPN_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [LPN_W-1:0] lpn_d_i,
  input  prot_t            prot_d_i,
  input  logic [LPN_W-1:0] key_i,
  output logic             match_o,
  output prot_t            prot_o
);
  logic [LPN_W-1:0] lpn_q;
  prot_t            prot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lpn_q  <= '1;
      prot_q <= PROT_PARK;
    end else if (wr_i) begin
      lpn_q  <= lpn_d_i;
      prot_q <= prot_d_i;
    end
  end

  assign match_o = (lpn_q == key_i);
  assign prot_o  = prot_q;

  a_r8_entry_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (lpn_q == $past(lpn_d_i)) && (prot_q == $past(prot_d_i)));
endmodule

// File: rtl/ipt_cam_prio.sv
module ipt_cam_prio #(
  parameter int unsigned N     = 128,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     match_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o,
  output logic             multi_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (match_i[i] && !any_o) begin
        gnt_o[i] = 1'b1;
        idx_o    = IDX_W'(i);
        any_o    = 1'b1;
      end
    end
  end

  assign multi_o = |(match_i & (match_i - 1'b1));

  a_r7_onehot_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  a_r7_grant_is_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> match_i[idx_o]);
  a_r7_multi_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_o == ($countones(match_i) > 1));
endmodule

// File: rtl/ipt_cam_perm.sv
module ipt_cam_perm
  import ipt_cam_pkg::*;
(
  input  prot_t prot_i,
  input  logic  we_i,
  input  logic  os_i,
  input  logic  sup_i,
  output logic  ok_o
);
  logic user_ok;
  assign user_ok = (prot_i == PROT_RW) || (prot_i == PROT_RO && !we_i);
  assign ok_o    = sup_i || (os_i && !we_i) || user_ok;
endmodule

// File: rtl/ipt_cam_xlat.sv
module ipt_cam_xlat
  import ipt_cam_pkg::*;
#(
  parameter int unsigned PAGES = 128,
  parameter int unsigned LPN_W = 10,
  parameter int unsigned OFS_W = 15,
  localparam int unsigned IDX_W = $clog2(PAGES),
  localparam int unsigned LA_W  = LPN_W + OFS_W,
  localparam int unsigned PA_W  = IDX_W + OFS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [LA_W-1:0]  la_i,
  input  logic             we_i,
  input  logic             os_i,
  input  logic             sup_i,
  input  logic             prog_i,
  input  logic [IDX_W-1:0] prog_idx_i,
  input  logic [LPN_W-1:0] prog_lpn_i,
  input  logic [1:0]       prog_prot_i,
  output logic             vld_o,
  output logic [PA_W-1:0]  pa_o,
  output logic             hit_o,
  output logic             abort_o,
  output logic             multi_o
);
  logic [LPN_W-1:0] key;
  logic [PAGES-1:0] match;
  logic [PAGES-1:0] gnt;
  prot_t            prot_arr [PAGES];
  logic [IDX_W-1:0] idx;
  logic             any_hit, multi, ok;

  assign key = la_i[LA_W-1:OFS_W];

  for (genvar g = 0; g < PAGES; g++) begin : g_ent
    ipt_cam_entry #(.LPN_W(LPN_W)) u_ent (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (prog_i && (prog_idx_i == IDX_W'(g))),
      .lpn_d_i (prog_lpn_i),
      .prot_d_i(prot_t'(prog_prot_i)),
      .key_i   (key),
      .match_o (match[g]),
      .prot_o  (prot_arr[g])
    );
  end

  ipt_cam_prio #(.N(PAGES)) u_prio (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .match_i(match),
    .gnt_o  (gnt),
    .idx_o  (idx),
    .any_o  (any_hit),
    .multi_o(multi)
  );

  ipt_cam_perm u_perm (
    .prot_i(prot_arr[idx]),
    .we_i  (we_i),
    .os_i  (os_i),
    .sup_i (sup_i),
    .ok_o  (ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      hit_o   <= 1'b0;
      abort_o <= 1'b0;
      multi_o <= 1'b0;
      pa_o    <= '0;
    end else begin
      vld_o   <= req_i;
      hit_o   <= req_i && any_hit;
      abort_o <= req_i && !(any_hit && ok);
      multi_o <= req_i && multi;
      if (req_i) pa_o <= {idx, la_i[OFS_W-1:0]};
    end
  end

  a_r2_resp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> vld_o);
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !vld_o && !hit_o && !abort_o && !multi_o);
  a_r3_miss_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o && !hit_o |-> abort_o);
  a_r7_multi_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_o |-> hit_o);
  a_r6_sup_hit_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && sup_i && any_hit |=> hit_o && !abort_o);
  a_r2_offset_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> pa_o[OFS_W-1:0] == $past(la_i[OFS_W-1:0]));
endmodule

// File: tb/ipt_cam_xlat_test.sv
module ipt_cam_xlat_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 0, rst_ni = 0;
  logic        req_i = 0, we_i = 0, os_i = 0, sup_i = 0, prog_i = 0;
  logic [24:0] la_i = '0;
  logic [6:0]  prog_idx_i = '0;
  logic [9:0]  prog_lpn_i = '0;
  logic [1:0]  prog_prot_i = '0;
  logic        vld_o, hit_o, abort_o, multi_o;
  logic [21:0] pa_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ipt_cam_xlat uut (.*);

  function automatic int map_lpn(int p);
    return (p * 37 + 5) % 1000;
  endfunction

  function automatic bit allowed(int prot, bit we, bit os, bit sup);
    if (sup) return 1;
    if (os && !we) return 1;
    return (prot == 0) || (prot == 1 && !we);
  endfunction

  task automatic check(string req, bit v, bit h, bit a, bit m, int pa, bit chk_pa,
                       bit ev, bit eh, bit ea, bit em, int epa);
    n_chk++;
    if (v !== ev || h !== eh || a !== ea || m !== em || (chk_pa && pa !== epa)) begin
      n_fail++;
      $display("FAIL %s: got vld=%0b hit=%0b abort=%0b multi=%0b pa=%0h, exp vld=%0b hit=%0b abort=%0b multi=%0b pa=%0h",
               req, v, h, a, m, pa, ev, eh, ea, em, epa);
    end
  endtask

  // drive at negedge, sample at the next negedge (one register stage)
  task automatic access(int lpn, int ofs, bit we, bit os, bit sup);
    req_i = 1; la_i = 25'((lpn << 15) | ofs); we_i = we; os_i = os; sup_i = sup;
    @(negedge clk_i);
    req_i = 0;
  endtask

  task automatic prog(int idx, int lpn, int prot);
    prog_i = 1; prog_idx_i = 7'(idx); prog_lpn_i = 10'(lpn); prog_prot_i = 2'(prot);
    @(negedge clk_i);
    prog_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    check("R1 in reset", vld_o, hit_o, abort_o, multi_o, 0, 0, 0, 0, 0, 0, 0);
    rst_ni = 1;
    @(negedge clk_i);
    check("R1 after reset", vld_o, hit_o, abort_o, multi_o, 0, 0, 0, 0, 0, 0, 0);
    // R1: all entries parked at 1023 level 3: lowest index, multi, user denied
    access(1023, 5, 0, 0, 0);
    check("R1 parked entries", vld_o, hit_o, abort_o, multi_o, pa_o, 1, 1, 1, 1, 1, 5);
    access(1023, 6, 1, 0, 1);
    check("R1 parked sup R6", vld_o, hit_o, abort_o, multi_o, pa_o, 1, 1, 1, 0, 1, 6);

    for (int p = 0; p < 128; p++) prog(p, map_lpn(p), p % 4);

    // R2 R4 R5 R6 sweep
    for (int p = 0; p < 128; p++)
      for (int md = 0; md < 3; md++)
        for (int w = 0; w < 2; w++) begin
          int ofs = (p * 131 + md * 7 + w * 4099) % 32768;
          bit os = (md == 1), sup = (md == 2);
          access(map_lpn(p), ofs, w[0], os, sup);
          check(md == 0 ? "R2/R4 user" : (md == 1 ? "R2/R5 os" : "R2/R6 sup"),
                vld_o, hit_o, abort_o, multi_o, pa_o, 1,
                1, 1, !allowed(p % 4, w[0], os, sup), 0, (p << 15) | ofs);
        end

    // R3 misses, all states
    for (int k = 0; k < 6; k++) begin
      access(1001 + k, k, k[0], k == 2, k >= 4);
      check("R3/R6 miss", vld_o, hit_o, abort_o, multi_o, 0, 0, 1, 0, 1, 0, 0);
    end

    // R10 idle cycle
    @(negedge clk_i);
    check("R10 idle", vld_o, hit_o, abort_o, multi_o, 0, 0, 0, 0, 0, 0, 0);

    // R8 same-cycle write sees old contents
    prog_i = 1; prog_idx_i = 7'd5; prog_lpn_i = 10'd1005; prog_prot_i = 2'd0;
    req_i = 1; la_i = 25'((1005 << 15) | 77); we_i = 1; os_i = 0; sup_i = 0;
    @(negedge clk_i);
    prog_i = 0; req_i = 0;
    check("R8 old contents", vld_o, hit_o, abort_o, multi_o, 0, 0, 1, 0, 1, 0, 0);
    access(1005, 77, 1, 0, 0);
    check("R8 new contents", vld_o, hit_o, abort_o, multi_o, pa_o, 1, 1, 1, 0, 0, (5 << 15) | 77);
    // R9 old mapping of entry 5 gone
    access(map_lpn(5), 3, 0, 0, 1);
    check("R9 old lpn misses", vld_o, hit_o, abort_o, multi_o, 0, 0, 1, 0, 1, 0, 0);

    // R7 duplicates: lowest index wins
    prog(9, 1005, 3);
    access(1005, 12, 0, 0, 0);
    check("R7 dup 5/9", vld_o, hit_o, abort_o, multi_o, pa_o, 1, 1, 1, 0, 1, (5 << 15) | 12);
    prog(3, 1005, 2);
    access(1005, 13, 0, 0, 0);
    check("R7 dup 3/5/9 level2 R4", vld_o, hit_o, abort_o, multi_o, pa_o, 1, 1, 1, 1, 1, (3 << 15) | 13);
    access(1005, 14, 1, 1, 0);
    check("R7 dup os write R5", vld_o, hit_o, abort_o, multi_o, pa_o, 1, 1, 1, 1, 1, (3 << 15) | 14);
    access(map_lpn(4), 15, 0, 0, 0);
    check("R7 single match", vld_o, hit_o, abort_o, multi_o, pa_o, 1, 1, 1, 0, 0, (4 << 15) | 15);

    @(negedge clk_i);
    check("R10 idle end", vld_o, hit_o, abort_o, multi_o, 0, 0, 0, 0, 0, 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule